// File: doc/BRIEF.md
# Word-wide feedback shift register with GF(2^8) alpha mixing

This block holds sixteen 32-bit words in a shift chain. Whenever it is told to advance, every word slides one position toward index 0 and a freshly computed word enters at index 15. The new word is not built from single-bit taps. It combines the word at index 0, shifted up by one byte, with the word at index 2 and the word at index 11, shifted down by one byte. Two byte-level field maps are also folded in. One multiplies the top byte of word 0 by a fixed field element alpha. The other divides the bottom byte of word 11 by alpha. Each map turns one byte into a 32-bit word.

The surrounding cipher sequencer uses the block in two ways. It first loads all sixteen words in parallel. During the setup phase it runs the block in init mode, where a 32-bit word from the nonlinear stage is also XORed into each new word. It then switches to stream mode, where that word is ignored. Words 0, 5 and 15 are brought out for the nonlinear stage, and the whole state is brought out for checking.

Both field maps are expanded into 256-entry constant tables while the design is elaborated, so one step takes one clock cycle.

Top module: `lfsr_top`

## Requirements
- R1: While `rst` is high, every stage is cleared to zero on the clock edge; after reset `state_o` reads all zero.
- R2: When `load_i` is high, stage i takes `load_words_i[32*i+31:32*i]` on the next edge. This holds even if `step_i` is also high, because load wins over step.
- R3: With `load_i` and `step_i` both low, the state does not change.
- R4: On a step (`step_i` high, `load_i` low), stage i takes the old stage i+1 for i = 0..14, and stage 15 takes the new feedback word.
- R5: In stream mode (`init_mode_i` = 0), the feedback word is the XOR of five terms: (stage0 << 8, truncated to 32 bits), MA(stage0[31:24]), stage2, (stage11 >> 8), and DA(stage11[7:0]).
- R6: Doubling a byte shifts it left by one bit, and XORs in 0xA9 when its old bit 7 was 1. MA(b) is the 32-bit word whose bytes, from bits 31:24 down to 7:0, are b doubled 23, 245, 48 and 239 times.
- R7: DA(b) is the 32-bit word whose bytes, from bits 31:24 down to 7:0, are b doubled 16, 39, 6 and 64 times, using the same doubling as R6.
- R8: In init mode (`init_mode_i` = 1), `inject_i` is XORed into the feedback word of R5. In stream mode `inject_i` has no effect on the state.
- R9: `s0_o`, `s5_o` and `s15_o` always equal stages 0, 5 and 15 of `state_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Parallel load of all stages |
| load_words_i | input | 512 | Load data, stage i in bits 32i+31:32i |
| step_i | input | 1 | Advance the register by one step |
| init_mode_i | input | 1 | 1 = init mode (inject mixed in), 0 = stream mode |
| inject_i | input | 32 | Word from the nonlinear stage |
| s0_o | output | 32 | Stage 0 |
| s5_o | output | 32 | Stage 5 |
| s15_o | output | 32 | Stage 15 |
| state_o | output | 512 | Full state, stage i in bits 32i+31:32i |

## Verification
The bench builds the block with its default parameters: sixteen 32-bit stages and doubling constant 0xA9. At that size a single loaded step isolates each field map. If only the top byte of stage 0 is non-zero, stage 15 becomes MA of that byte. If only the low byte of stage 11 is non-zero, stage 15 becomes DA of that byte. This allows all 256 input bytes of both maps to be checked exhaustively. Long runs of steps from random loaded states, in both modes and with random inject words, are then compared word for word against an arithmetic model kept in the bench.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned N_STAGES = 16;
    localparam logic [7:0]  ALPHA_C  = 8'hA9;

    typedef enum logic {
        MODE_STREAM = 1'b0,
        MODE_INIT   = 1'b1
    } lfsr_mode_e;

    // Exponents for the four bytes of each map, most significant byte first
    localparam logic [3:0][7:0] MUL_EXPS = {8'd23, 8'd245, 8'd48, 8'd239};
    localparam logic [3:0][7:0] DIV_EXPS = {8'd16, 8'd39,  8'd6,  8'd64};

    typedef struct packed {
        logic [WORD_W-1:0] head;
        logic [WORD_W-1:0] tap_a;
        logic [WORD_W-1:0] tap_b;
    } fb_taps_t;

    function automatic logic [7:0] gf_double(input logic [7:0] v, input logic [7:0] c);
        logic [7:0] sh;
        sh = {v[6:0], 1'b0};
        return v[7] ? (sh ^ c) : sh;
    endfunction

    function automatic logic [7:0] gf_double_n(input logic [7:0] v, input int unsigned n,
                                               input logic [7:0] c);
        logic [7:0] acc;
        acc = v;
        for (int unsigned k = 0; k < 256; k++) begin
            if (k < n) acc = gf_double(acc, c);
        end
        return acc;
    endfunction

    function automatic logic [31:0] alpha_word(input logic [7:0] b, input logic [3:0][7:0] exps,
                                               input logic [7:0] c);
        logic [3:0][7:0] res;
        for (int lane = 0; lane < 4; lane++) begin
            res[lane] = gf_double_n(b, int'(exps[lane]), c);
        end
        return res;
    endfunction

endpackage

// File: rtl/alpha_map.sv
module alpha_map
    import lfsr_pkg::*;
#(
    parameter logic [3:0][7:0] EXPS = MUL_EXPS,
    parameter logic [7:0]      POLY = ALPHA_C
) (
    input  logic [7:0]  byte_i,
    output logic [31:0] word_o
);
    localparam int unsigned ENTRIES = 256;

    logic [31:0] table_w [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        localparam logic [31:0] ENTRY = alpha_word(8'(i), EXPS, POLY);
        assign table_w[i] = ENTRY;
    end

    assign word_o = table_w[byte_i];

endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
    import lfsr_pkg::*;
#(
    parameter logic [7:0] POLY = ALPHA_C
) (
    input  fb_taps_t    taps_i,
    input  lfsr_mode_e  mode_i,
    input  logic [31:0] inject_i,
    output logic [31:0] fb_o
);
    logic [31:0] mul_w;
    logic [31:0] div_w;
    logic [31:0] mix_w;

    alpha_map #(.EXPS(MUL_EXPS), .POLY(POLY)) u_mul (
        .byte_i (taps_i.head[31:24]),
        .word_o (mul_w)
    );

    alpha_map #(.EXPS(DIV_EXPS), .POLY(POLY)) u_div (
        .byte_i (taps_i.tap_b[7:0]),
        .word_o (div_w)
    );

    always_comb begin
        mix_w = {taps_i.head[23:0], 8'h00} ^ mul_w ^ taps_i.tap_a
              ^ {8'h00, taps_i.tap_b[31:8]} ^ div_w;
        fb_o  = (mode_i == MODE_INIT) ? (mix_w ^ inject_i) : mix_w;
    end

endmodule

// File: rtl/lfsr_top.sv
module lfsr_top
    import lfsr_pkg::*;
#(
    parameter int unsigned STAGES = N_STAGES,
    parameter int unsigned TAP_A  = 2,
    parameter int unsigned TAP_B  = 11,
    parameter int unsigned TAP_M  = 5,
    parameter logic [7:0]  POLY   = ALPHA_C
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_i,
    input  logic [STAGES*32-1:0]     load_words_i,
    input  logic                     step_i,
    input  logic                     init_mode_i,
    input  logic [31:0]              inject_i,
    output logic [31:0]              s0_o,
    output logic [31:0]              s5_o,
    output logic [31:0]              s15_o,
    output logic [STAGES*32-1:0]     state_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][31:0] stage_q;
    logic [STAGES-1:0][31:0] stage_d;
    logic [31:0]             fb_w;
    fb_taps_t                taps;
    lfsr_mode_e              mode;

    assign mode = lfsr_mode_e'(init_mode_i);
    assign taps = '{head: stage_q[0], tap_a: stage_q[TAP_A], tap_b: stage_q[TAP_B]};

    lfsr_feedback #(.POLY(POLY)) u_fb (
        .taps_i   (taps),
        .mode_i   (mode),
        .inject_i (inject_i),
        .fb_o     (fb_w)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_next
        if (i == LAST) begin : g_top
            assign stage_d[i] = fb_w;
        end else begin : g_mid
            assign stage_d[i] = stage_q[i+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (load_i) begin
            stage_q <= load_words_i;
        end else if (step_i) begin
            stage_q <= stage_d;
        end
    end

    assign state_o = stage_q;
    assign s0_o    = stage_q[0];
    assign s5_o    = stage_q[TAP_M];
    assign s15_o   = stage_q[LAST];

endmodule

// File: rtl/lfsr_top_chk.sv
module lfsr_top_chk #(
    parameter int unsigned STAGES = 16,
    parameter int unsigned TAP_M  = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 load_i,
    input logic [STAGES*32-1:0] load_words_i,
    input logic                 step_i,
    input logic [31:0]          s0_o,
    input logic [31:0]          s5_o,
    input logic [31:0]          s15_o,
    input logic [STAGES*32-1:0] state_o
);
    localparam int unsigned W = STAGES * 32;

    // R1: the first cycle out of reset sees an all-zero state
    p_zero_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_o == '0));

    // R2: a load overwrites every stage regardless of step
    p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (state_o == $past(load_words_i)));

    // R3: no request leaves the state unchanged
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_i) |=> $stable(state_o));

    // R4: a step moves each stage down by one index
    p_shift_down_r4: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> (state_o[W-33:0] == $past(state_o[W-1:32])));

    // R9: the tap outputs follow the state vector
    p_taps_match_r9: assert property (@(posedge clk) disable iff (rst)
        (s0_o == state_o[31:0]) && (s5_o == state_o[TAP_M*32 +: 32])
        && (s15_o == state_o[W-1 -: 32]));

endmodule

bind lfsr_top lfsr_top_chk #(.STAGES(STAGES), .TAP_M(TAP_M)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .load_words_i (load_words_i),
    .step_i       (step_i),
    .s0_o         (s0_o),
    .s5_o         (s5_o),
    .s15_o        (s15_o),
    .state_o      (state_o)
);

// File: tb/lfsr_top_test.sv
module lfsr_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 load_i;
    logic [NS*32-1:0]     load_words_i;
    logic                 step_i;
    logic                 init_mode_i;
    logic [31:0]          inject_i;
    logic [31:0]          s0_o, s5_o, s15_o;
    logic [NS*32-1:0]     state_o;

    logic [NS-1:0][31:0]  model;
    int                   n_vec = 0;
    int                   n_bad = 0;
    bit                   done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_top uut (
        .clk(clk), .rst(rst), .load_i(load_i), .load_words_i(load_words_i),
        .step_i(step_i), .init_mode_i(init_mode_i), .inject_i(inject_i),
        .s0_o(s0_o), .s5_o(s5_o), .s15_o(s15_o), .state_o(state_o)
    );

    // Reference arithmetic, written from the requirements (R6, R7)
    function automatic logic [7:0] twice(logic [7:0] v);
        return v[7] ? ({v[6:0], 1'b0} ^ 8'hA9) : {v[6:0], 1'b0};
    endfunction

    function automatic logic [7:0] twice_n(logic [7:0] v, int n);
        if (n == 0) return v;
        return twice(twice_n(v, n - 1));
    endfunction

    function automatic logic [31:0] ref_mul(logic [7:0] b);
        return {twice_n(b, 23), twice_n(b, 245), twice_n(b, 48), twice_n(b, 239)};
    endfunction

    function automatic logic [31:0] ref_div(logic [7:0] b);
        return {twice_n(b, 16), twice_n(b, 39), twice_n(b, 6), twice_n(b, 64)};
    endfunction

    function automatic logic [NS-1:0][31:0] ref_step(logic [NS-1:0][31:0] s, logic im,
                                                      logic [31:0] inj);
        logic [NS-1:0][31:0] n;
        logic [31:0] v;
        v = (s[0] << 8) ^ ref_mul(s[0][31:24]) ^ s[2] ^ (s[11] >> 8) ^ ref_div(s[11][7:0]);
        if (im) v = v ^ inj;
        for (int i = 0; i < NS - 1; i++) n[i] = s[i+1];
        n[NS-1] = v;
        return n;
    endfunction

    function automatic logic [NS-1:0][31:0] rand_state();
        logic [NS-1:0][31:0] r;
        for (int i = 0; i < NS; i++) r[i] = $urandom;
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_word(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        n_vec++;
        if (state_o !== model) begin
            n_bad++;
            $display("FAIL %s: actual %0128h expected %0128h", req, state_o, model);
        end
        // R9: tap outputs mirror stages 0, 5, 15
        check_word("R9", s0_o, model[0]);
        check_word("R9", s5_o, model[5]);
        check_word("R9", s15_o, model[15]);
    endtask

    task automatic do_load(logic [NS-1:0][31:0] w);
        load_i = 1'b1; load_words_i = w; step_i = 1'b0;
        tick();
        load_i = 1'b0;
        model = w;
    endtask

    task automatic do_step(logic im, logic [31:0] inj);
        step_i = 1'b1; init_mode_i = im; inject_i = inj;
        tick();
        step_i = 1'b0;
        model = ref_step(model, im, inj);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0][31:0] w;
        rst = 1'b1; load_i = 1'b0; load_words_i = '0; step_i = 1'b0;
        init_mode_i = 1'b0; inject_i = '0;
        @(negedge clk);
        load_i = 1'b1; load_words_i = '1; step_i = 1'b1;
        tick(); tick();
        load_i = 1'b0; step_i = 1'b0;
        rst = 1'b0;
        model = '0;
        check_state("R1");

        // R6: exhaustive alpha-multiply through the top byte of stage 0
        for (int b = 0; b < 256; b++) begin
            w = '0; w[0] = {8'(b), 24'h0};
            do_load(w);
            do_step(1'b0, 32'hDEAD_BEEF);
            check_word("R6", s15_o, ref_mul(8'(b)));
            check_state("R4");
        end

        // R7: exhaustive alpha-divide through the low byte of stage 11
        for (int b = 0; b < 256; b++) begin
            w = '0; w[11] = {24'h0, 8'(b)};
            do_load(w);
            do_step(1'b0, 32'h0);
            check_word("R7", s15_o, ref_div(8'(b)));
        end

        // R5 / R8: long runs in both modes with random inject words
        for (int run = 0; run < 8; run++) begin
            do_load(rand_state());
            check_state("R2");
            for (int k = 0; k < 40; k++) begin
                do_step(run[0], $urandom);
                check_state(run[0] ? "R8" : "R5");
            end
        end

        // R8: inject ignored in stream mode, two inject values give same result
        w = rand_state();
        do_load(w);
        do_step(1'b0, 32'hFFFF_FFFF);
        check_word("R8", s15_o, ref_step(w, 1'b0, 32'h0)[15]);

        // R3: idle cycles hold state even with mode and inject toggling
        for (int k = 0; k < 5; k++) begin
            init_mode_i = k[0]; inject_i = $urandom;
            tick();
            check_state("R3");
        end

        // R2: load wins over a simultaneous step
        w = rand_state();
        load_i = 1'b1; step_i = 1'b1; load_words_i = w; init_mode_i = 1'b1;
        tick();
        load_i = 1'b0; step_i = 1'b0;
        model = w;
        check_state("R2");

        // R1: reset in the middle of a run
        do_step(1'b1, 32'h1234_5678);
        rst = 1'b1; step_i = 1'b1;
        tick();
        rst = 1'b0; step_i = 1'b0;
        model = '0;
        check_state("R1");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule